// File: doc/BRIEF.md
# Weighted Scan Transition Counter

This block scores how much switching a scan test set causes in one fixed scan-cell order. Each test pattern arrives as a stream of beats, one scan cell per beat. The first beat is the cell next to the scan input and the last beat is the cell next to the scan output. Every beat carries two bits: the stimulus value loaded into that cell and the response value captured in it.

A change of value between neighbouring cells is charged by where it sits in the chain:
- A stimulus change costs more the nearer it is to the scan output, because it ripples through more cells while loading.
- A response change costs more the nearer it is to the scan input, because it ripples through more cells while unloading.

The block reports a load score and an unload score for each pattern. It also keeps set-wide totals and the largest per-pattern score. An optional mode also charges the single toggle at the seam between the previous pattern's unload and the next pattern's load.

The chain length is sampled at the first beat of each pattern. A pattern of the wrong length is flagged and left out of the totals. The totals saturate instead of wrapping, and a flag reports that this happened. A test set ends with a marker on the last beat of its last pattern, and the next set starts from clean totals.

Top module: `shift_toggle_scorer`

## Requirements
- R1: Cells are numbered 1 to s from the scan input, where s is the sampled length. When the stimulus bits of cells k and k+1 differ, k is added to the pattern's load score `res_in`.
- R2: When the response bits of cells k and k+1 differ, s-k is added to the pattern's unload score `res_out`.
- R3: `res_valid` is high for exactly one cycle, in the cycle after the clock edge that accepts a pattern's last beat. `res_in`, `res_out`, `res_err` and `set_done` are valid in that cycle. No other cycle raises `res_valid`.
- R4: A 6-cell chain with stimulus and response both 1,0,1,1,1,0 (cell 1 first) gives `res_in` = 8 and `res_out` = 10.
- R5: The seam charge applies when `seam_en` = 1. The stimulus bit of cell s of the current pattern is compared with a stored reference bit. If they differ, 1 is added to `res_in`. The reference bit is the response bit of cell 1 of the last pattern that had no length error. It is 0 after reset and at the start of a new set. With `seam_en` = 0 nothing is added.
- R6: `cfg_len` is sampled only on the beat that carries `in_sop`. Changing it later in the pattern has no effect on that pattern's scores or length check.
- R7: A pattern whose accepted beat count differs from s gives `res_err` = 1 and sets `len_err`, which stays set until reset. Such a pattern changes neither the totals, nor `peak`, nor the seam reference bit. Its `res_in` and `res_out` carry no defined value.
- R8: Over the error-free patterns of the current set:
  - `tot_in` is the sum of `res_in`.
  - `tot_out` is the sum of `res_out`.
  - `tot_sum` is the sum of `res_in` + `res_out`.

  All three update in the same cycle as `res_valid`.
- R9: `peak` is the largest `res_in` + `res_out` of any error-free pattern in the current set.
- R10: Each total is clamped at 2^TOT_W-1 and does not wrap. Clamping any total sets `sat_flag`, which stays set until reset.
- R11: If `in_eos` is high on a pattern's last beat, `set_done` pulses together with that pattern's `res_valid`. The next accepted `in_sop` beat clears the totals and `peak` to 0 and sets the seam reference bit to 0.
- R12: A synchronous `rst` clears all outputs, totals, flags and the seam reference bit. `in_ready` is low while `rst` is high and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_len | input | LW | Chain length s, sampled on the first beat of a pattern |
| seam_en | input | 1 | Enables the seam charge between patterns |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| in_sop | input | 1 | First beat of a pattern (cell 1) |
| in_eop | input | 1 | Last beat of a pattern |
| in_eos | input | 1 | Last pattern of the set, meaningful with in_eop |
| in_stim | input | 1 | Stimulus bit of the current cell |
| in_resp | input | 1 | Response bit of the current cell |
| res_valid | output | 1 | Per-pattern result strobe |
| res_in | output | PW | Weighted load score of the pattern |
| res_out | output | PW | Weighted unload score of the pattern |
| res_err | output | 1 | Pattern had a length error |
| set_done | output | 1 | Result belongs to the last pattern of the set |
| tot_in | output | TOT_W | Load total of the set |
| tot_out | output | TOT_W | Unload total of the set |
| tot_sum | output | TOT_W | Combined total of the set |
| peak | output | PW+1 | Largest per-pattern combined score in the set |
| len_err | output | 1 | Sticky length-error flag |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Every per-pattern result, total, `peak` and sticky flag is due in the single cycle after the edge that accepts the pattern's last beat. The driver drives beats on falling edges. After the last beat it checks `res_valid` at the very next falling edge. A monitor pops the expected record at each `res_valid` falling edge, and stray or late strobes show up as unexpected or leftover records. Set clearing happens at the edge that accepts the next first beat, which comes after the monitor has sampled the previous totals. Reset effects are checked at the falling edge after one reset edge.

// File: rtl/wts_pkg.sv
package wts_pkg;

    // Walker phase: waiting for a first beat, or inside a pattern.
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_e;

endpackage

// File: rtl/wts_weights.sv
// Position weights for the neighbour pair (k, k+1) of a chain of length s.
module wts_weights #(
    parameter int LW = 4,
    parameter int PW = 7
) (
    input  logic [LW-1:0] pos,
    input  logic [LW-1:0] len,
    output logic [PW-1:0] w_load,
    output logic [PW-1:0] w_unload
);

    logic [LW-1:0] dist_to_in;

    always_comb begin
        dist_to_in = len - pos;
        w_load     = PW'(pos);
        w_unload   = PW'(dist_to_in);
    end

endmodule

// File: rtl/wts_walker.sv
// Walks one pattern cell by cell and produces its two weighted scores.
module wts_walker
    import wts_pkg::*;
#(
    parameter int LW = 4,
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat,
    input  logic          sop,
    input  logic          eop,
    input  logic          stim,
    input  logic          resp,
    input  logic [LW-1:0] cfg_len,
    input  logic          seam_en,
    input  logic          fresh,
    output logic          done,
    output logic          err,
    output logic [PW-1:0] sc_in,
    output logic [PW-1:0] sc_out
);

    typedef struct packed {
        walk_e         st;
        logic [LW-1:0] idx;
        logic [LW-1:0] len;
        logic          over;
        logic          last_stim;
        logic          last_resp;
        logic          first_resp;
        logic          ref_resp;
        logic [PW-1:0] acc_in;
        logic [PW-1:0] acc_out;
    } walk_t;

    walk_t         walk_q, walk_d;
    logic [PW-1:0] w_load, w_unload;
    logic          seam_hit;

    wts_weights #(.LW(LW), .PW(PW)) u_wt (
        .pos      (walk_q.idx),
        .len      (walk_q.len),
        .w_load   (w_load),
        .w_unload (w_unload)
    );

    always_comb begin
        walk_d   = walk_q;
        done     = 1'b0;
        err      = 1'b0;
        sc_in    = '0;
        sc_out   = '0;
        seam_hit = 1'b0;
        if (beat) begin
            if (sop) begin
                walk_d.st         = WALK_BUSY;
                walk_d.idx        = LW'(1);
                walk_d.len        = cfg_len;
                walk_d.over       = 1'b0;
                walk_d.last_stim  = stim;
                walk_d.last_resp  = resp;
                walk_d.first_resp = resp;
                walk_d.acc_in     = '0;
                walk_d.acc_out    = '0;
                if (fresh) begin
                    walk_d.ref_resp = 1'b0;
                end
            end else if (walk_q.st == WALK_BUSY) begin
                if (walk_q.idx >= walk_q.len) begin
                    walk_d.over = 1'b1;
                end else begin
                    walk_d.idx = walk_q.idx + LW'(1);
                end
                if (stim != walk_q.last_stim) begin
                    walk_d.acc_in = walk_q.acc_in + w_load;
                end
                if (resp != walk_q.last_resp) begin
                    walk_d.acc_out = walk_q.acc_out + w_unload;
                end
                walk_d.last_stim = stim;
                walk_d.last_resp = resp;
            end
            if (eop && (sop || walk_q.st == WALK_BUSY)) begin
                done      = 1'b1;
                walk_d.st = WALK_IDLE;
                err       = walk_d.over || (walk_d.idx != walk_d.len);
                seam_hit  = seam_en && (stim != walk_d.ref_resp);
                sc_in     = walk_d.acc_in + PW'(seam_hit);
                sc_out    = walk_d.acc_out;
                if (!err) begin
                    walk_d.ref_resp = walk_d.first_resp;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

endmodule

// File: rtl/wts_accum.sv
// Registers per-pattern results and keeps saturating set totals and peak.
module wts_accum #(
    parameter int PW = 7,
    parameter int TW = 8,
    localparam int SW = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          open_beat,
    input  logic          done,
    input  logic          err,
    input  logic          eos,
    input  logic [PW-1:0] sc_in,
    input  logic [PW-1:0] sc_out,
    output logic          res_valid,
    output logic [PW-1:0] res_in,
    output logic [PW-1:0] res_out,
    output logic          res_err,
    output logic          set_done,
    output logic [TW-1:0] tot_in,
    output logic [TW-1:0] tot_out,
    output logic [TW-1:0] tot_sum,
    output logic [SW-1:0] peak,
    output logic          len_err,
    output logic          sat_flag,
    output logic          fresh
);

    typedef struct packed {
        logic          res_valid;
        logic [PW-1:0] res_in;
        logic [PW-1:0] res_out;
        logic          res_err;
        logic          set_done;
        logic [TW-1:0] tot_in;
        logic [TW-1:0] tot_out;
        logic [TW-1:0] tot_sum;
        logic [SW-1:0] peak;
        logic          len_err;
        logic          sat;
        logic          fresh;
    } acc_t;

    acc_t          acc_q, acc_d;
    logic [SW-1:0] pat_sum;
    logic [TW:0]   r_in, r_out, r_sum;

    // Upper bit flags a clamp, lower bits carry the clamped sum.
    function automatic logic [TW:0] sat_add(input logic [TW-1:0] a, input logic [TW-1:0] b);
        logic [TW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s[TW]) begin
            return {1'b1, {TW{1'b1}}};
        end
        return s;
    endfunction

    always_comb begin
        acc_d           = acc_q;
        acc_d.res_valid = 1'b0;
        acc_d.set_done  = 1'b0;
        if (open_beat && acc_q.fresh) begin
            acc_d.fresh   = 1'b0;
            acc_d.tot_in  = '0;
            acc_d.tot_out = '0;
            acc_d.tot_sum = '0;
            acc_d.peak    = '0;
        end
        pat_sum = SW'(sc_in) + SW'(sc_out);
        r_in    = sat_add(acc_d.tot_in, TW'(sc_in));
        r_out   = sat_add(acc_d.tot_out, TW'(sc_out));
        r_sum   = sat_add(acc_d.tot_sum, TW'(pat_sum));
        if (done) begin
            acc_d.res_valid = 1'b1;
            acc_d.res_in    = sc_in;
            acc_d.res_out   = sc_out;
            acc_d.res_err   = err;
            acc_d.set_done  = eos;
            if (err) begin
                acc_d.len_err = 1'b1;
            end else begin
                acc_d.tot_in  = r_in[TW-1:0];
                acc_d.tot_out = r_out[TW-1:0];
                acc_d.tot_sum = r_sum[TW-1:0];
                if (r_in[TW] || r_out[TW] || r_sum[TW]) begin
                    acc_d.sat = 1'b1;
                end
                if (pat_sum > acc_d.peak) begin
                    acc_d.peak = pat_sum;
                end
            end
            if (eos) begin
                acc_d.fresh = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign res_valid = acc_q.res_valid;
    assign res_in    = acc_q.res_in;
    assign res_out   = acc_q.res_out;
    assign res_err   = acc_q.res_err;
    assign set_done  = acc_q.set_done;
    assign tot_in    = acc_q.tot_in;
    assign tot_out   = acc_q.tot_out;
    assign tot_sum   = acc_q.tot_sum;
    assign peak      = acc_q.peak;
    assign len_err   = acc_q.len_err;
    assign sat_flag  = acc_q.sat;
    assign fresh     = acc_q.fresh;

endmodule

// File: rtl/shift_toggle_scorer.sv
// Streaming scorer of position-weighted scan load and unload toggles.
module shift_toggle_scorer #(
    parameter int MAX_LEN  = 64,
    parameter int MAX_PATS = 1024,
    parameter int TOT_W    = $clog2(MAX_PATS * MAX_LEN * MAX_LEN + 1),
    localparam int LW      = $clog2(MAX_LEN + 1),
    localparam int PW      = $clog2(MAX_LEN * MAX_LEN + 1),
    localparam int SW      = PW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LW-1:0]    cfg_len,
    input  logic             seam_en,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic             in_eos,
    input  logic             in_stim,
    input  logic             in_resp,
    output logic             res_valid,
    output logic [PW-1:0]    res_in,
    output logic [PW-1:0]    res_out,
    output logic             res_err,
    output logic             set_done,
    output logic [TOT_W-1:0] tot_in,
    output logic [TOT_W-1:0] tot_out,
    output logic [TOT_W-1:0] tot_sum,
    output logic [SW-1:0]    peak,
    output logic             len_err,
    output logic             sat_flag
);

    logic          beat;
    logic          fresh;
    logic          done;
    logic          err;
    logic [PW-1:0] sc_in, sc_out;

    assign in_ready = ~rst;
    assign beat     = in_valid & in_ready;

    wts_walker #(.LW(LW), .PW(PW)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .beat    (beat),
        .sop     (in_sop),
        .eop     (in_eop),
        .stim    (in_stim),
        .resp    (in_resp),
        .cfg_len (cfg_len),
        .seam_en (seam_en),
        .fresh   (fresh),
        .done    (done),
        .err     (err),
        .sc_in   (sc_in),
        .sc_out  (sc_out)
    );

    wts_accum #(.PW(PW), .TW(TOT_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .open_beat (beat & in_sop),
        .done      (done),
        .err       (err),
        .eos       (in_eos),
        .sc_in     (sc_in),
        .sc_out    (sc_out),
        .res_valid (res_valid),
        .res_in    (res_in),
        .res_out   (res_out),
        .res_err   (res_err),
        .set_done  (set_done),
        .tot_in    (tot_in),
        .tot_out   (tot_out),
        .tot_sum   (tot_sum),
        .peak      (peak),
        .len_err   (len_err),
        .sat_flag  (sat_flag),
        .fresh     (fresh)
    );

endmodule

// File: rtl/wts_chk.sv
module wts_chk #(
    parameter int PW = 7,
    parameter int TW = 8,
    localparam int SW = PW + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_sop,
    input logic          in_eop,
    input logic          res_valid,
    input logic [PW-1:0] res_in,
    input logic [PW-1:0] res_out,
    input logic          res_err,
    input logic          set_done,
    input logic [TW-1:0] tot_in,
    input logic [TW-1:0] tot_out,
    input logic [TW-1:0] tot_sum,
    input logic [SW-1:0] peak,
    input logic          len_err,
    input logic          sat_flag
);

    logic [SW-1:0] seen_sum;
    assign seen_sum = SW'(res_in) + SW'(res_out);

    // R3
    result_after_eop_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid && in_ready && in_eop));

    // R3
    single_beat_result_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_sop && in_eop) |=> res_valid);

    // R7
    len_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        len_err |=> len_err);

    // R7
    err_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_err) |-> len_err);

    // R9
    peak_covers_result_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_err) |-> (peak >= seen_sum));

    // R10
    sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        sat_flag |=> sat_flag);

    // R8
    sum_dominates_chk: assert property (@(posedge clk) disable iff (rst)
        (tot_sum >= tot_in) && (tot_sum >= tot_out));

    // R11
    set_done_with_result_chk: assert property (@(posedge clk) disable iff (rst)
        set_done |-> res_valid);

endmodule

bind shift_toggle_scorer wts_chk #(.PW(PW), .TW(TOT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .res_valid (res_valid),
    .res_in    (res_in),
    .res_out   (res_out),
    .res_err   (res_err),
    .set_done  (set_done),
    .tot_in    (tot_in),
    .tot_out   (tot_out),
    .tot_sum   (tot_sum),
    .peak      (peak),
    .len_err   (len_err),
    .sat_flag  (sat_flag)
);

// File: tb/sim_shift_toggle_scorer.sv
module sim_shift_toggle_scorer;

    localparam int MAX_LEN = 8;
    localparam int TOT_W   = 8;
    localparam int LW      = $clog2(MAX_LEN + 1);
    localparam int PW      = $clog2(MAX_LEN * MAX_LEN + 1);
    localparam int SW      = PW + 1;
    localparam int TMAX    = (1 << TOT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LW-1:0]    cfg_len = '0;
    logic             seam_en = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             in_sop = 1'b0, in_eop = 1'b0, in_eos = 1'b0;
    logic             in_stim = 1'b0, in_resp = 1'b0;
    logic             res_valid;
    logic [PW-1:0]    res_in, res_out;
    logic             res_err, set_done;
    logic [TOT_W-1:0] tot_in, tot_out, tot_sum;
    logic [SW-1:0]    peak;
    logic             len_err, sat_flag;

    always #4 clk = ~clk;

    shift_toggle_scorer #(.MAX_LEN(MAX_LEN), .MAX_PATS(4), .TOT_W(TOT_W)) u0 (
        .clk(clk), .rst(rst), .cfg_len(cfg_len), .seam_en(seam_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop),
        .in_eop(in_eop), .in_eos(in_eos), .in_stim(in_stim), .in_resp(in_resp),
        .res_valid(res_valid), .res_in(res_in), .res_out(res_out),
        .res_err(res_err), .set_done(set_done), .tot_in(tot_in),
        .tot_out(tot_out), .tot_sum(tot_sum), .peak(peak),
        .len_err(len_err), .sat_flag(sat_flag)
    );

    typedef struct {
        int    e_in, e_out;
        bit    e_err, e_done;
        int    t_in, t_out, t_sum, pk;
        bit    lerr, sat;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;

    // Reference model state, derived from the requirements
    int m_ti = 0, m_to = 0, m_ts = 0, m_pk = 0;
    bit m_ref = 1'b0, m_fresh = 1'b0, m_lerr = 1'b0, m_sat = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int clampv(input int v);
        if (v > TMAX) begin
            m_sat = 1'b1;
            return TMAX;
        end
        return v;
    endfunction

    task automatic send(input logic [7:0] st, input logic [7:0] rs, input int nb,
                        input int len, input int alt_len, input bit eos, input string tag);
        exp_t e;
        int   pin, pout;
        bit   err;
        if (m_fresh) begin
            m_ti = 0; m_to = 0; m_ts = 0; m_pk = 0; m_ref = 1'b0; m_fresh = 1'b0;
        end
        err  = (nb != len);
        pin  = 0;
        pout = 0;
        for (int k = 1; k < nb; k++) begin
            if (st[k-1] != st[k]) pin += k;
            if (rs[k-1] != rs[k]) pout += len - k;
        end
        if (!err) begin
            if (seam_en && (st[nb-1] != m_ref)) pin++;
            m_ti = clampv(m_ti + pin);
            m_to = clampv(m_to + pout);
            m_ts = clampv(m_ts + pin + pout);
            if (pin + pout > m_pk) m_pk = pin + pout;
            m_ref = rs[0];
        end else begin
            m_lerr = 1'b1;
        end
        if (eos) m_fresh = 1'b1;
        e.e_in = pin; e.e_out = pout; e.e_err = err; e.e_done = eos;
        e.t_in = m_ti; e.t_out = m_to; e.t_sum = m_ts; e.pk = m_pk;
        e.lerr = m_lerr; e.sat = m_sat; e.tag = tag;
        q.push_back(e);
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (b == 0);
            in_eop   = (b == nb - 1);
            in_eos   = eos && (b == nb - 1);
            in_stim  = st[b];
            in_resp  = rs[b];
            cfg_len  = (b == 0) ? LW'(len) : LW'(alt_len);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop = 1'b0; in_eop = 1'b0; in_eos = 1'b0;
        // R3: result strobe one cycle after the last beat is taken
        chk(res_valid == 1'b1, "R3 res_valid timing", int'(res_valid), 1);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R3 unexpected res_valid", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(res_err == e.e_err, {e.tag, " R7 res_err"}, int'(res_err), int'(e.e_err));
                if (!e.e_err) begin
                    chk(int'(res_in) == e.e_in, {e.tag, " res_in"}, int'(res_in), e.e_in);
                    chk(int'(res_out) == e.e_out, {e.tag, " res_out"}, int'(res_out), e.e_out);
                end
                chk(set_done == e.e_done, "R11 set_done", int'(set_done), int'(e.e_done));
                chk(int'(tot_in) == e.t_in, "R8 tot_in", int'(tot_in), e.t_in);
                chk(int'(tot_out) == e.t_out, "R8 tot_out", int'(tot_out), e.t_out);
                chk(int'(tot_sum) == e.t_sum, "R8 tot_sum", int'(tot_sum), e.t_sum);
                chk(int'(peak) == e.pk, "R9 peak", int'(peak), e.pk);
                chk(len_err == e.lerr, "R7 len_err", int'(len_err), int'(e.lerr));
                chk(sat_flag == e.sat, "R10 sat_flag", int'(sat_flag), int'(e.sat));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog: got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(in_ready == 1'b0, "R12 in_ready in reset", int'(in_ready), 0);
        chk(res_valid == 1'b0, "R12 res_valid in reset", int'(res_valid), 0);
        chk(tot_sum == '0, "R12 tot_sum in reset", int'(tot_sum), 0);
        chk(len_err == 1'b0 && sat_flag == 1'b0, "R12 flags in reset",
            int'({len_err, sat_flag}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R12 in_ready after reset", int'(in_ready), 1);

        // Set 1, no seam charge
        seam_en = 1'b0;
        send(8'h1D, 8'h1D, 6, 6, 6, 1'b0, "R4");
        send(8'h01, 8'h80, 8, 8, 8, 1'b0, "R1 R2 edges");
        send(8'h80, 8'h01, 8, 8, 8, 1'b0, "R1 R2 far edges");
        send(8'h06, 8'h05, 4, 4, 7, 1'b0, "R6 late cfg_len");
        send(8'h1F, 8'h00, 5, 8, 8, 1'b0, "R7 short");
        send(8'h0F, 8'h0A, 4, 3, 3, 1'b0, "R7 long");
        send(8'h01, 8'h01, 1, 1, 1, 1'b0, "R1 single cell");
        send(8'hFF, 8'h00, 8, 8, 8, 1'b1, "R11 set end");

        // Set 2, seam charge on, starts from a zero reference
        seam_en = 1'b1;
        send(8'h1F, 8'h1E, 5, 5, 5, 1'b0, "R5 seam after new set");
        send(8'h03, 8'h05, 3, 3, 3, 1'b0, "R5 no seam");
        send(8'h00, 8'h00, 2, 4, 4, 1'b0, "R7 error keeps reference");
        send(8'h02, 8'h00, 2, 2, 2, 1'b0, "R5 reference kept");
        send(8'h03, 8'h01, 2, 2, 2, 1'b1, "R5 seam charged");

        // Set 3, saturation
        seam_en = 1'b0;
        for (int p = 0; p < 10; p++) begin
            send(8'h55, 8'hAA, 8, 8, 8, (p == 9), "R10 heavy pattern");
        end

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R3 results outstanding", q.size(), 0);

        // R12: reset clears state
        rst = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R12 in_ready in reset", int'(in_ready), 0);
        chk(tot_in == '0 && tot_out == '0 && tot_sum == '0, "R12 totals cleared",
            int'(tot_sum), 0);
        chk(peak == '0, "R12 peak cleared", int'(peak), 0);
        chk(len_err == 1'b0, "R12 len_err cleared", int'(len_err), 0);
        chk(sat_flag == 1'b0, "R12 sat_flag cleared", int'(sat_flag), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule